// File: doc/BRIEF.md
# Polarity-Adjusting Interrupt Mask Controller

This block is a front-end stage between a set of peripheral interrupt lines and a parent interrupt controller. Each raw line is brought into the local clock domain through a two-flop synchronizer. It may then be inverted by a per-line polarity bit and blocked by a per-line mask bit. The result is presented to the parent on a registered output, one output per line.

The block has two build variants. The pass-through variant drives each output straight from the adjusted, masked line. The latched variant turns a rising edge of the adjusted line into a sticky status bit. That bit stays set until software writes a one to its clear position. Software reaches the block through a small register bus with 16-bit data and byte addresses. Mask, polarity and status are three banks with sixteen lines per word, and every bank can be read back so that single lines can be changed with read-modify-write.

Top module: `polmask_intc`

## Requirements
- R1: Byte address bits [5:4] pick the bank: 0 is mask, 1 is polarity, 2 is status/clear. Bits [3:2] pick the word, which is 4 bytes apart from the next. Line n lives in bit n%16 of word n/16 of each bank.
- R2: After reset every implemented mask bit reads 1, every polarity bit reads 0, every status bit reads 0, and all outputs are 0.
- R3: A line whose mask bit is 1 never drives its output. A line whose mask bit is 0 drives its output from the adjusted signal (pass-through variant) or from its status bit (latched variant).
- R4: A polarity bit of 1 inverts the synchronized raw input before edge detection and masking. A polarity bit of 0 leaves it unchanged.
- R5: In the pass-through variant, a raw input change shows at the output on the third rising clock edge after it. A mask write shows on the second edge after the write cycle.
- R6: In the latched variant, a 0-to-1 transition of the adjusted line sets its status bit. The bit stays set after the line falls, and reading the status bank returns it.
- R7: In the latched variant, a write to the status bank clears every line whose data bit is 1. Bits written 0 leave status unchanged. The output follows the clear on the first edge after the write cycle.
- R8: When a status set event and a write-one clear of the same line fall on the same clock edge, the status bit ends up set. A clear while the adjusted line stays high, with no new edge, does clear the bit.
- R9: A write with address bits above [5] nonzero, bits [1:0] nonzero, bank 3, or a word index at or past ceil(NUM_LINES/16) changes nothing, and a read of such an address returns 0. Bits for lines at or beyond NUM_LINES read 0 and ignore writes.
- R10: In the pass-through variant the status bank reads 0 and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| irq_raw | input | NUM_LINES | Raw peripheral interrupt lines, asynchronous |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as a read strobe |
| irq_out | output | NUM_LINES | Registered per-line outputs to the parent controller |

## Verification
Register readback is combinational, so a read is sampled in the cycle of its strobe, a quarter period after the edge that ends that cycle. A write lands on the edge that ends its cycle. A mask or polarity change therefore reaches the outputs on the second edge, and a status clear reaches them on the first. A raw input change crosses two synchronizer flops and the output register, so it is due on the third edge. Each expected value carries the cycle number in which it is due, and it is compared only in that cycle. The bench checks the cycle before as well, to confirm that nothing arrives early. The set-versus-clear collision is built by placing the clear write two cycles after the raw edge, which makes the two events fall on the same clock edge.

// File: rtl/polmask_pkg.sv
package polmask_pkg;

  localparam int LINES_PER_WORD = 16;

  typedef enum logic [1:0] {
    BANK_MASK = 2'd0,
    BANK_POL  = 2'd1,
    BANK_STAT = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;

  function automatic int words_for(input int lines);
    return (lines + LINES_PER_WORD - 1) / LINES_PER_WORD;
  endfunction

endpackage

// File: rtl/polmask_sync.sv
module polmask_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/polmask_regs.sv
module polmask_regs
  import polmask_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [15:0]          bus_wdata,
  output logic [15:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] status_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] clr_o
);

  localparam int NWORD = words_for(NUM_LINES);
  localparam int PADW  = NWORD * LINES_PER_WORD;
  localparam logic [PADW-1:0] LIVE = {PADW{1'b1}} >> (PADW - NUM_LINES);

  bank_e            bank;
  logic [1:0]       idx;
  logic             hit;
  logic             wr_hit;
  logic             mask_en;
  logic             pol_en;
  logic [PADW-1:0]  word_bits;
  logic [PADW-1:0]  wide_w;
  logic [PADW-1:0]  mask_q, mask_d;
  logic [PADW-1:0]  pol_q, pol_d;
  logic [PADW-1:0]  clr_pad;
  logic [PADW-1:0]  stat_pad;
  logic [15:0]      rd_word;

  // address decode
  always_comb begin
    bank   = bank_e'(bus_addr[5:4]);
    idx    = bus_addr[3:2];
    hit    = bus_sel
          && (bus_addr[ADDR_W-1:6] == '0)
          && (bus_addr[1:0] == 2'b00)
          && (bank != BANK_NONE)
          && (int'(idx) < NWORD);
    wr_hit = hit && bus_wr;
  end

  for (genvar r = 0; r < NWORD; r++) begin : g_word
    assign word_bits[r*LINES_PER_WORD +: LINES_PER_WORD] =
      {LINES_PER_WORD{int'(idx) == r}};
  end

  assign wide_w   = {NWORD{bus_wdata}};
  assign stat_pad = PADW'(status_i);

  // next-state
  always_comb begin
    mask_en = wr_hit && (bank == BANK_MASK);
    pol_en  = wr_hit && (bank == BANK_POL);
    mask_d  = ((mask_q & ~word_bits) | (wide_w & word_bits)) & LIVE;
    pol_d   = ((pol_q  & ~word_bits) | (wide_w & word_bits)) & LIVE;
    clr_pad = (wr_hit && (bank == BANK_STAT)) ? (wide_w & word_bits & LIVE) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= LIVE;
      pol_q  <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (pol_en)  pol_q  <= pol_d;
    end
  end

  // readback
  always_comb begin
    rd_word = '0;
    if (hit && !bus_wr) begin
      for (int r = 0; r < NWORD; r++) begin
        if (int'(idx) == r) begin
          case (bank)
            BANK_MASK: rd_word = mask_q[r*LINES_PER_WORD +: LINES_PER_WORD];
            BANK_POL:  rd_word = pol_q[r*LINES_PER_WORD +: LINES_PER_WORD];
            BANK_STAT: rd_word = stat_pad[r*LINES_PER_WORD +: LINES_PER_WORD];
            default:   rd_word = '0;
          endcase
        end
      end
    end
  end

  assign bus_rdata = rd_word;
  assign mask_o    = mask_q[NUM_LINES-1:0];
  assign pol_o     = pol_q[NUM_LINES-1:0];
  assign clr_o     = clr_pad[NUM_LINES-1:0];

endmodule

// File: rtl/polmask_event.sv
module polmask_event #(
  parameter int NUM_LINES = 32,
  parameter bit LATCHED   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] sync_i,
  input  logic [NUM_LINES-1:0] pol_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] status_o,
  output logic [NUM_LINES-1:0] rise_o,
  output logic [NUM_LINES-1:0] out_o
);

  logic [NUM_LINES-1:0] adj;
  logic [NUM_LINES-1:0] flag;
  logic [NUM_LINES-1:0] out_q, out_d;

  assign adj = sync_i ^ pol_i;

  if (LATCHED) begin : g_latch
    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] stat_q, stat_d;
    logic [NUM_LINES-1:0] rise;

    always_comb begin
      rise   = adj & ~prev_q;
      stat_d = (stat_q & ~clr_i) | rise;   // set dominates clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= '0;
        stat_q <= '0;
      end else begin
        prev_q <= adj;
        stat_q <= stat_d;
      end
    end

    assign flag     = stat_d;
    assign status_o = stat_q;
    assign rise_o   = rise;
  end else begin : g_pass
    assign flag     = adj;
    assign status_o = '0;
    assign rise_o   = '0;
  end

  always_comb out_d = flag & ~mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign out_o = out_q;

endmodule

// File: rtl/polmask_intc.sv
module polmask_intc
  import polmask_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter bit LATCHED   = 1'b1,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_raw,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [15:0]          bus_wdata,
  output logic [15:0]          bus_rdata,
  output logic [NUM_LINES-1:0] irq_out
);

  logic [1:0]           rst_pipe_q;
  logic                 rst_core_n;
  logic [NUM_LINES-1:0] sync_s;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] pol_q;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] status_q;
  logic [NUM_LINES-1:0] rise_vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  polmask_sync #(.WIDTH(NUM_LINES), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (irq_raw),
    .sync_o  (sync_s)
  );

  polmask_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .status_i  (status_q),
    .mask_o    (mask_q),
    .pol_o     (pol_q),
    .clr_o     (clr_vec)
  );

  polmask_event #(.NUM_LINES(NUM_LINES), .LATCHED(LATCHED)) u_event (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sync_i   (sync_s),
    .pol_i    (pol_q),
    .mask_i   (mask_q),
    .clr_i    (clr_vec),
    .status_o (status_q),
    .rise_o   (rise_vec),
    .out_o    (irq_out)
  );

endmodule

// File: rtl/polmask_intc_chk.sv
module polmask_intc_chk #(
  parameter int NUM_LINES = 32,
  parameter bit LATCHED   = 1'b1,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [15:0]          bus_rdata,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] status_q,
  input logic [NUM_LINES-1:0] clr_vec,
  input logic [NUM_LINES-1:0] rise_vec,
  input logic [NUM_LINES-1:0] irq_out
);

  localparam int NWORD = (NUM_LINES + 15) / 16;

  logic mapped;
  always_comb mapped = (bus_addr[ADDR_W-1:6] == '0) && (bus_addr[1:0] == 2'b00)
                    && (bus_addr[5:4] != 2'd3) && (int'(bus_addr[3:2]) < NWORD);

  // a line masked in the previous cycle cannot be driven now
  assert_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & $past(mask_q)) == '0);

  assert_unmapped_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !mapped) |-> (bus_rdata == 16'h0000));

  if (LATCHED) begin : g_latch_chk
    // status only falls where a one was written to its clear position
    assert_zero_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_q) & ~status_q & ~$past(clr_vec)) == '0);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & $past(rise_vec)) == $past(rise_vec));
  end else begin : g_pass_chk
    assert_status_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr[5:4] == 2'd2) |-> (bus_rdata == 16'h0000));
  end

endmodule

bind polmask_intc polmask_intc_chk #(
  .NUM_LINES (NUM_LINES),
  .LATCHED   (LATCHED),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .mask_q    (mask_q),
  .status_q  (status_q),
  .clr_vec   (clr_vec),
  .rise_vec  (rise_vec),
  .irq_out   (irq_out)
);

// File: tb/polmask_intc_tb.sv
module polmask_intc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NL         = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] raw;
  logic          bus_sel, bus_wr;
  logic [7:0]    bus_addr;
  logic [15:0]   bus_wdata;
  logic [15:0]   rd_fiq, rd_lvl;
  logic [NL-1:0] out_fiq, out_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  polmask_intc #(.NUM_LINES(NL), .LATCHED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_raw(raw), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_fiq), .irq_out(out_fiq));

  polmask_intc #(.NUM_LINES(NL), .LATCHED(1'b0)) u_dut_lvl (
    .clk(clk), .rst_n(rst_n), .irq_raw(raw), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_lvl), .irq_out(out_lvl));

  typedef struct {
    int            due;
    int            kind;   // 0 latched out, 1 pass out, 2 latched rdata, 3 pass rdata
    logic [NL-1:0] exp;
    string         tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;

  function automatic logic [NL-1:0] sample(input int kind);
    case (kind)
      0:       return out_fiq;
      1:       return out_lvl;
      2:       return NL'(rd_fiq);
      default: return NL'(rd_lvl);
    endcase
  endfunction

  // monitor: compare every item due in this cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #(CLK_PERIOD/4);
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due == cyc) begin
          logic [NL-1:0] act;
          act = sample(q[i].kind);
          n_cmp++;
          if (act !== q[i].exp) begin
            n_bad++;
            $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                     q[i].tag, q[i].kind, cyc, act, q[i].exp);
          end
          q.delete(i);
        end
      end
    end
  end

  task automatic push(input int d, input int kind, input logic [NL-1:0] e, input string t);
    item_t it;
    it.due = cyc + d; it.kind = kind; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] ef, input logic [15:0] el,
                    input string t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    push(1, 2, NL'(ef), t);
    push(1, 3, NL'(el), t);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
    end
  endtask

  task automatic set_raw(input logic [NL-1:0] v);
    @(negedge clk);
    raw = v; bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic run_seq();
    rst_n = 1'b0; raw = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R2 reset state
    rd(8'h00, 16'hFFFF, 16'hFFFF, "R2");
    rd(8'h04, 16'h000F, 16'h000F, "R2");
    rd(8'h10, 16'h0000, 16'h0000, "R2");
    rd(8'h20, 16'h0000, 16'h0000, "R2");
    idle(1);
    push(1, 0, '0, "R2");
    push(1, 1, '0, "R2");

    // R9 unmapped and unimplemented locations
    wr(8'h08, 16'h0000);
    idle(1);
    rd(8'h08, 16'h0000, 16'h0000, "R9");
    wr(8'h01, 16'h0000);
    wr(8'h30, 16'h0000);
    wr(8'h40, 16'h0000);
    idle(1);
    rd(8'h00, 16'hFFFF, 16'hFFFF, "R9");
    rd(8'h30, 16'h0000, 16'h0000, "R9");
    wr(8'h04, 16'hFFF0);
    idle(1);
    rd(8'h04, 16'h0000, 16'h0000, "R9");
    wr(8'h14, 16'hFFF0);
    idle(1);
    rd(8'h14, 16'h0000, 16'h0000, "R9");

    // R3 / R5 masking and latency; lines 0, 3 unmasked, 16..19 unmasked
    wr(8'h00, 16'hFFF6);
    idle(1);
    set_raw(20'h10009);
    push(2, 1, '0, "R5");
    push(3, 1, 20'h10009, "R3");
    push(3, 0, 20'h10009, "R6");
    idle(4);
    wr(8'h00, 16'hFFFF);
    push(1, 1, 20'h10009, "R5");
    push(2, 1, 20'h10000, "R3");
    push(2, 0, 20'h10000, "R3");
    idle(3);

    // R6 status stays after the input falls
    set_raw('0);
    push(3, 1, '0, "R6");
    push(3, 0, 20'h10000, "R6");
    idle(4);
    rd(8'h20, 16'h0009, 16'h0000, "R6,R10");
    rd(8'h24, 16'h0001, 16'h0000, "R6,R10");

    // R7 write-one clear
    wr(8'h20, 16'h0001);
    idle(1);
    rd(8'h20, 16'h0008, 16'h0000, "R7");
    wr(8'h24, 16'h0000);
    idle(1);
    rd(8'h24, 16'h0001, 16'h0000, "R7");
    wr(8'h24, 16'h0001);
    push(1, 0, '0, "R7");
    idle(1);
    rd(8'h24, 16'h0000, 16'h0000, "R7");

    // R8 set and clear on the same edge: line 5
    set_raw(20'h00020);
    idle(1);
    wr(8'h20, 16'h0020);
    idle(1);
    rd(8'h20, 16'h0028, 16'h0000, "R8");
    wr(8'h20, 16'h0020);
    idle(1);
    rd(8'h20, 16'h0008, 16'h0000, "R8");

    // R4 polarity on line 2
    wr(8'h00, 16'hFFFB);
    idle(1);
    wr(8'h10, 16'h0004);
    push(2, 1, 20'h00004, "R4");
    push(2, 0, 20'h00004, "R4");
    idle(3);
    rd(8'h10, 16'h0004, 16'h0004, "R4");
    set_raw(20'h00024);
    push(3, 1, '0, "R4");
    push(3, 0, 20'h00004, "R6");
    idle(4);

    // R1 bit placement of line 19
    wr(8'h14, 16'h0008);
    push(2, 1, 20'h80000, "R1");
    push(2, 0, 20'h80004, "R1");
    idle(3);
    rd(8'h14, 16'h0008, 16'h0008, "R1");
    rd(8'h24, 16'h0008, 16'h0000, "R1");

    // R10 pass-through status bank ignores writes; R7 bulk clear
    wr(8'h20, 16'hFFFF);
    push(1, 0, 20'h80000, "R7");
    idle(1);
    rd(8'h20, 16'h0000, 16'h0000, "R7,R10");
    idle(5);
  endtask

  initial begin
    fork
      run_seq();
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1..: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    if (q.size() != 0) begin
      foreach (q[i]) begin
        n_bad++;
        $display("FAIL %s never compared actual=none expected=%h", q[i].tag, q[i].exp);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule